// File: doc/BRIEF.md
# Multi-mode packet FIFO bus port

This block sits between a 64-bit host data bus and the transmit and receive packet FIFOs of one network port. The host writes packet words into the transmit FIFO and reads packet words out of the receive FIFO. A static mode input decides how the single data bus and its active-low byte enables are used. In the full arrangement, all 64 bits are shared between both directions. In the split arrangement, the upper half carries transmit writes and the lower half carries receive reads, and both can happen in the same cycle. In the narrow arrangement, only the lower 32 bits and lower four enables are used, in both directions. The bus pads are modelled as separate in and out vectors, with one output enable per half.

Each FIFO entry holds a 64-bit word, a byte-valid mask and a start-of-packet bit. Transmit writes must carry a non-empty contiguous run of asserted enables. A write that breaks this rule is dropped and raises a sticky error flag. On a receive read, the head entry is presented on the bus in the same cycle and is removed at the next clock edge. The host can ask for the entry to be kept at the head so that it is read again. The far side of each FIFO (transmit drain, receive fill) is brought out as plain ports for the network side.

Top module: `pktbus_port`

## Requirements
- R1: With mode_i = 0 (full) or 3 (also full), a write strobe stores bus_din_i[63:0] as the entry data, the inverse of bus_be_n_i[7:0] as the mask (enable bit n covers data bits 8n+7..8n), and sop_i as the start bit.
- R2: With mode_i = 1 (split), a write stores bus_din_i[63:32] in entry data bits 31:0 with upper data zero, takes the mask bits 3:0 from ~bus_be_n_i[7:4] with upper mask bits zero, and takes the start bit from sop_tx_i. bus_din_i[31:0], bus_be_n_i[3:0] and sop_i are ignored.
- R3: With mode_i = 2 (narrow), a write stores bus_din_i[31:0] and the mask ~bus_be_n_i[3:0] in the low half, with upper data and mask zero, and takes the start bit from sop_i. bus_din_i[63:32] and bus_be_n_i[7:4] are ignored.
- R4: A write whose derived mask is zero or not one contiguous run of ones leaves the transmit FIFO unchanged. It sets be_err_o from the next edge until reset.
- R5: In full mode, a receive read of a non-empty FIFO drives bus_dout_o = head data, bus_be_n_o = ~head mask and sop_o = head start bit in the same cycle, with bus_oe_o = 2'b11. The entry is removed at the next edge.
- R6: In split and narrow modes, a receive read drives only the low half: bus_dout_o[31:0] = head data[31:0] and bus_be_n_o[3:0] = ~head mask[3:0]. bus_dout_o[63:32] = 0, bus_be_n_o[7:4] = 4'hF and bus_oe_o = 2'b01.
- R7: Without a read, or on a read of an empty FIFO, bus_dout_o = 0, bus_be_n_o = 8'hFF and sop_o = 0. Without a read, bus_oe_o = 0. sop_oe_o is 1 at all times in split mode and equals rx_rd_i otherwise.
- R8: A read with rx_keep_i = 1 presents the head entry but does not remove it, so the next read returns the same entry.
- R9: Each FIFO holds 16 entries, with full and empty flags. A write or fill while full is ignored, and a read or drain while empty is ignored.
- R10: In full and narrow modes, a write strobe in the same cycle as a receive read is ignored. In split mode, both take effect.
- R11: After reset both FIFOs are empty and be_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | Bus arrangement: 0/3 full, 1 split, 2 narrow |
| tx_wr_i | input | 1 | Host write strobe into transmit FIFO |
| bus_din_i | input | 64 | Data bus, inbound |
| bus_be_n_i | input | 8 | Active-low byte enables, inbound |
| sop_i | input | 1 | Shared start-of-packet line, inbound |
| sop_tx_i | input | 1 | Transmit start-of-packet line, used in split mode |
| rx_rd_i | input | 1 | Host receive read select |
| rx_keep_i | input | 1 | Keep the entry being read at the head |
| bus_dout_o | output | 64 | Data bus, outbound |
| bus_be_n_o | output | 8 | Active-low byte enables, outbound |
| bus_oe_o | output | 2 | Output enables: bit 0 low half, bit 1 high half |
| sop_o | output | 1 | Receive start-of-packet indication |
| sop_oe_o | output | 1 | Output enable of the start-of-packet line |
| be_err_o | output | 1 | Sticky bad byte-enable flag |
| tx_pop_i | input | 1 | Network-side drain of transmit FIFO |
| tx_data_o | output | 64 | Transmit head data |
| tx_mask_o | output | 8 | Transmit head byte mask |
| tx_sop_o | output | 1 | Transmit head start bit |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_push_i | input | 1 | Network-side fill of receive FIFO |
| rx_data_i | input | 64 | Receive fill data |
| rx_mask_i | input | 8 | Receive fill byte mask |
| rx_sop_i | input | 1 | Receive fill start bit |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |

## Verification
Receive bus outputs depend combinationally on the FIFO head and the read select, so they are due in the same cycle as the read. Transmit entries, FIFO flags and be_err_o change at the rising edge that takes the strobe, and are due one cycle later. The driver changes inputs at the falling edge. The scoreboard monitor samples 1 ns after that edge, so a read's outputs are compared in the cycle they are driven, and the monitor pops its queue in step with the edge that removes the entry. Flag and error checks are made one idle cycle after the strobe, at the same sampling point.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

    localparam int BUS_W      = 64;
    localparam int HALF_W     = BUS_W / 2;
    localparam int LANES      = BUS_W / 8;
    localparam int HALF_LANES = LANES / 2;

    typedef enum logic [1:0] {
        MODE_FULL     = 2'd0,
        MODE_SPLIT    = 2'd1,
        MODE_NARROW   = 2'd2,
        MODE_FULL_ALT = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [LANES-1:0] mask;
        logic             sop;
    } pkt_word_t;

    // true when the mask is non-zero and its ones form a single run
    function automatic logic mask_ok(input logic [LANES-1:0] m);
        logic [LANES-1:0] lsb;
        logic [LANES-1:0] sum;
        lsb = m & (~m + 1'b1);
        sum = m + lsb;
        return (m != '0) && ((sum & m) == '0);
    endfunction

endpackage

// File: rtl/pbp_fifo.sv
module pbp_fifo
    import pbp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  pkt_word_t                  wr_word,
    output pkt_word_t                  head,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    pkt_word_t      mem [DEPTH];
    logic [AW-1:0]  rd_ptr, wr_ptr;
    logic           push_ok, pop_ok;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(level));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> $stable(level));

endmodule

// File: rtl/pbp_tx_lane.sv
module pbp_tx_lane
    import pbp_pkg::*;
(
    input  bus_mode_e          mode,
    input  logic               wr,
    input  logic               rd,
    input  logic [BUS_W-1:0]   din,
    input  logic [LANES-1:0]   be_n,
    input  logic               sop_shared,
    input  logic               sop_split,
    output logic               push,
    output logic               bad,
    output pkt_word_t          word
);

    logic blocked;
    logic attempt;

    always_comb begin
        word    = '0;
        blocked = 1'b0;
        unique case (mode)
            MODE_SPLIT: begin
                word.data[HALF_W-1:0]     = din[BUS_W-1:HALF_W];
                word.mask[HALF_LANES-1:0] = ~be_n[LANES-1:HALF_LANES];
                word.sop                  = sop_split;
            end
            MODE_NARROW: begin
                word.data[HALF_W-1:0]     = din[HALF_W-1:0];
                word.mask[HALF_LANES-1:0] = ~be_n[HALF_LANES-1:0];
                word.sop                  = sop_shared;
                blocked                   = rd;
            end
            default: begin
                word.data = din;
                word.mask = ~be_n;
                word.sop  = sop_shared;
                blocked   = rd;
            end
        endcase
    end

    assign attempt = wr && !blocked;
    assign push    = attempt && mask_ok(word.mask);
    assign bad     = attempt && !mask_ok(word.mask);

endmodule

// File: rtl/pbp_rx_lane.sv
module pbp_rx_lane
    import pbp_pkg::*;
(
    input  bus_mode_e          mode,
    input  logic               rd,
    input  logic               keep,
    input  logic               empty,
    input  pkt_word_t          head,
    output logic               pop,
    output logic [BUS_W-1:0]   dout,
    output logic [LANES-1:0]   be_n,
    output logic [1:0]         oe,
    output logic               sop,
    output logic               sop_oe
);

    logic hit;

    assign hit = rd && !empty;
    assign pop = hit && !keep;

    always_comb begin
        dout   = '0;
        be_n   = '1;
        sop    = 1'b0;
        oe     = 2'b00;
        sop_oe = rd;
        unique case (mode)
            MODE_SPLIT, MODE_NARROW: begin
                oe = {1'b0, rd};
                if (mode == MODE_SPLIT) sop_oe = 1'b1;
                if (hit) begin
                    dout[HALF_W-1:0]     = head.data[HALF_W-1:0];
                    be_n[HALF_LANES-1:0] = ~head.mask[HALF_LANES-1:0];
                    sop                  = head.sop;
                end
            end
            default: begin
                oe = {rd, rd};
                if (hit) begin
                    dout = head.data;
                    be_n = ~head.mask;
                    sop  = head.sop;
                end
            end
        endcase
    end

endmodule

// File: rtl/pktbus_port.sv
module pktbus_port
    import pbp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic        tx_wr_i,
    input  logic [63:0] bus_din_i,
    input  logic [7:0]  bus_be_n_i,
    input  logic        sop_i,
    input  logic        sop_tx_i,
    input  logic        rx_rd_i,
    input  logic        rx_keep_i,
    output logic [63:0] bus_dout_o,
    output logic [7:0]  bus_be_n_o,
    output logic [1:0]  bus_oe_o,
    output logic        sop_o,
    output logic        sop_oe_o,
    output logic        be_err_o,
    input  logic        tx_pop_i,
    output logic [63:0] tx_data_o,
    output logic [7:0]  tx_mask_o,
    output logic        tx_sop_o,
    output logic        tx_empty_o,
    output logic        tx_full_o,
    input  logic        rx_push_i,
    input  logic [63:0] rx_data_i,
    input  logic [7:0]  rx_mask_i,
    input  logic        rx_sop_i,
    output logic        rx_empty_o,
    output logic        rx_full_o
);

    localparam int CW = $clog2(DEPTH+1);

    bus_mode_e       mode;
    pkt_word_t       tx_word, tx_head, rx_word, rx_head;
    logic            tx_push, tx_bad, rx_pop;
    logic [CW-1:0]   tx_level, rx_level;

    assign mode    = bus_mode_e'(mode_i);
    assign rx_word = '{data: rx_data_i, mask: rx_mask_i, sop: rx_sop_i};

    pbp_tx_lane u_tx_lane (
        .mode       (mode),
        .wr         (tx_wr_i),
        .rd         (rx_rd_i),
        .din        (bus_din_i),
        .be_n       (bus_be_n_i),
        .sop_shared (sop_i),
        .sop_split  (sop_tx_i),
        .push       (tx_push),
        .bad        (tx_bad),
        .word       (tx_word)
    );

    pbp_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (tx_push),
        .pop     (tx_pop_i),
        .wr_word (tx_word),
        .head    (tx_head),
        .full    (tx_full_o),
        .empty   (tx_empty_o),
        .level   (tx_level)
    );

    pbp_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_push_i),
        .pop     (rx_pop),
        .wr_word (rx_word),
        .head    (rx_head),
        .full    (rx_full_o),
        .empty   (rx_empty_o),
        .level   (rx_level)
    );

    pbp_rx_lane u_rx_lane (
        .mode   (mode),
        .rd     (rx_rd_i),
        .keep   (rx_keep_i),
        .empty  (rx_empty_o),
        .head   (rx_head),
        .pop    (rx_pop),
        .dout   (bus_dout_o),
        .be_n   (bus_be_n_o),
        .oe     (bus_oe_o),
        .sop    (sop_o),
        .sop_oe (sop_oe_o)
    );

    assign tx_data_o = tx_empty_o ? '0 : tx_head.data;
    assign tx_mask_o = tx_empty_o ? '0 : tx_head.mask;
    assign tx_sop_o  = tx_empty_o ? 1'b0 : tx_head.sop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_err_o <= 1'b0;
        end else if (tx_bad) begin
            be_err_o <= 1'b1;
        end
    end

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_err_o |=> be_err_o);

    // R4
    bad_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bad && !tx_pop_i) |=> (be_err_o && $stable(tx_level)));

    // R8
    keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_i && rx_keep_i && !rx_push_i) |=> $stable(rx_level));

    // R5
    read_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_i && !rx_keep_i && !rx_empty_o && !rx_push_i)
            |=> (rx_level == $past(rx_level) - 1'b1));

    // R10
    shared_bus_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd1 && rx_rd_i && tx_wr_i && !tx_pop_i) |=> $stable(tx_level));

    // R6
    split_upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 || mode_i == 2'd2) |-> (!bus_oe_o[1] && bus_be_n_o[7:4] == 4'hF));

endmodule

// File: tb/pktbus_port_tb_top.sv
`timescale 1ns/1ps
module pktbus_port_tb_top;

    typedef struct {
        logic [63:0] d;
        logic [7:0]  m;
        logic        s;
    } item_t;

    localparam logic [1:0] M_FULL = 2'd0, M_SPLIT = 2'd1, M_NARROW = 2'd2, M_FULL3 = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        tx_wr_i, sop_i, sop_tx_i, rx_rd_i, rx_keep_i, tx_pop_i, rx_push_i, rx_sop_i;
    logic [63:0] bus_din_i, rx_data_i;
    logic [7:0]  bus_be_n_i, rx_mask_i;
    logic [63:0] bus_dout_o, tx_data_o;
    logic [7:0]  bus_be_n_o, tx_mask_o;
    logic [1:0]  bus_oe_o;
    logic        sop_o, sop_oe_o, be_err_o, tx_sop_o, tx_empty_o, tx_full_o, rx_empty_o, rx_full_o;

    int    n_chk  = 0;
    int    n_fail = 0;
    logic  exp_err = 1'b0;
    item_t tx_q[$];
    item_t rx_q[$];

    always #2 clk = ~clk;

    pktbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tx_wr_i(tx_wr_i),
        .bus_din_i(bus_din_i), .bus_be_n_i(bus_be_n_i), .sop_i(sop_i), .sop_tx_i(sop_tx_i),
        .rx_rd_i(rx_rd_i), .rx_keep_i(rx_keep_i), .bus_dout_o(bus_dout_o),
        .bus_be_n_o(bus_be_n_o), .bus_oe_o(bus_oe_o), .sop_o(sop_o), .sop_oe_o(sop_oe_o),
        .be_err_o(be_err_o), .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o), .tx_mask_o(tx_mask_o),
        .tx_sop_o(tx_sop_o), .tx_empty_o(tx_empty_o), .tx_full_o(tx_full_o),
        .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .rx_mask_i(rx_mask_i), .rx_sop_i(rx_sop_i),
        .rx_empty_o(rx_empty_o), .rx_full_o(rx_full_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic contig(input logic [7:0] m);
        int runs = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i] && (i == 0 || !m[i-1])) runs++;
        end
        return runs == 1;
    endfunction

    task automatic drive_zero();
        tx_wr_i = 0; bus_din_i = '0; bus_be_n_i = 8'hFF; sop_i = 0; sop_tx_i = 0;
        rx_rd_i = 0; rx_keep_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_data_i = '0;
        rx_mask_i = '0; rx_sop_i = 0;
    endtask

    task automatic tx_write(input logic [63:0] d, input logic [7:0] ben,
                            input logic s, input logic st, input logic rd);
        item_t it;
        logic  blocked;
        @(negedge clk);
        drive_zero();
        tx_wr_i = 1; bus_din_i = d; bus_be_n_i = ben; sop_i = s; sop_tx_i = st; rx_rd_i = rd;
        case (mode_i)
            M_SPLIT:  begin it.d = {32'h0, d[63:32]}; it.m = {4'h0, ~ben[7:4]}; it.s = st; end
            M_NARROW: begin it.d = {32'h0, d[31:0]};  it.m = {4'h0, ~ben[3:0]}; it.s = s;  end
            default:  begin it.d = d;                 it.m = ~ben;              it.s = s;  end
        endcase
        blocked = rd && (mode_i != M_SPLIT);
        if (!blocked) begin
            if (contig(it.m)) begin
                if (tx_q.size() < 16) tx_q.push_back(it);
            end else begin
                exp_err = 1'b1;
            end
        end
    endtask

    task automatic rx_load(input logic [63:0] d, input logic [7:0] m, input logic s);
        item_t it;
        @(negedge clk);
        drive_zero();
        rx_push_i = 1; rx_data_i = d; rx_mask_i = m; rx_sop_i = s;
        it.d = d; it.m = m; it.s = s;
        if (rx_q.size() < 16) rx_q.push_back(it);
    endtask

    task automatic rx_read(input logic keep);
        @(negedge clk);
        drive_zero();
        rx_rd_i = 1; rx_keep_i = keep;
    endtask

    task automatic tx_drain();
        @(negedge clk);
        drive_zero();
        tx_pop_i = 1;
    endtask

    task automatic idle();
        @(negedge clk);
        drive_zero();
        #1;
    endtask

    // monitor: compares bus and drain outputs against the scoreboard queues
    always begin : monitor
        item_t       it;
        logic [63:0] ed;
        logic [7:0]  eb;
        logic        es;
        logic [1:0]  eo;
        @(negedge clk);
        #1;
        if (rst_n && rx_rd_i) begin
            ed = '0; eb = 8'hFF; es = 0;
            eo = (mode_i == M_SPLIT || mode_i == M_NARROW) ? 2'b01 : 2'b11;
            if (rx_q.size() > 0) begin
                it = rx_q[0];
                es = it.s;
                if (eo == 2'b01) begin
                    ed = {32'h0, it.d[31:0]}; eb = {4'hF, ~it.m[3:0]};
                end else begin
                    ed = it.d; eb = ~it.m;
                end
                if (!rx_keep_i) void'(rx_q.pop_front());
            end
            check("R5/R6/R8 read data", bus_dout_o, ed);
            check("R5/R6/R8 read enables", {56'h0, bus_be_n_o}, {56'h0, eb});
            check("R5/R6 read sop", {63'h0, sop_o}, {63'h0, es});
            check("R5/R6 read oe", {62'h0, bus_oe_o}, {62'h0, eo});
        end
        if (rst_n && tx_pop_i) begin
            if (tx_q.size() > 0) begin
                it = tx_q.pop_front();
                check("R1/R2/R3 tx data", tx_data_o, it.d);
                check("R1/R2/R3 tx mask", {56'h0, tx_mask_o}, {56'h0, it.m});
                check("R1/R2/R3 tx sop", {63'h0, tx_sop_o}, {63'h0, it.s});
            end else begin
                check("R9 tx empty on drain", {63'h0, tx_empty_o}, 64'h1);
            end
        end
    end

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stimulus
        drive_zero();
        mode_i = M_FULL;
        rst_n  = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        // R11 reset state, R7 idle outputs
        check("R11 tx empty", {63'h0, tx_empty_o}, 64'h1);
        check("R11 rx empty", {63'h0, rx_empty_o}, 64'h1);
        check("R11 err clear", {63'h0, be_err_o}, 64'h0);
        check("R7 idle dout", bus_dout_o, 64'h0);
        check("R7 idle be", {56'h0, bus_be_n_o}, 64'hFF);
        check("R7 idle oe", {62'h0, bus_oe_o}, 64'h0);
        check("R7 sop_oe full idle", {63'h0, sop_oe_o}, 64'h0);

        // R1 full mode writes
        tx_write(64'h0123_4567_89AB_CDEF, 8'h00, 1, 0, 0);
        tx_write(64'hDEAD_BEEF_CAFE_F00D, 8'hF0, 0, 1, 0);
        tx_write(64'h1111_2222_3333_4444, 8'h81, 0, 0, 0);
        mode_i = M_FULL3;
        tx_write(64'hA5A5_5A5A_0F0F_F0F0, 8'hFE, 1, 0, 0);
        repeat (4) tx_drain();
        idle();
        check("R1 drained empty", {63'h0, tx_empty_o}, 64'h1);

        // R2 split writes
        mode_i = M_SPLIT;
        idle();
        check("R7 sop_oe split idle", {63'h0, sop_oe_o}, 64'h1);
        tx_write(64'h89AB_CDEF_FFFF_FFFF, 8'h0F, 0, 1, 0);
        tx_write(64'h7654_3210_0000_0000, 8'hCA, 1, 0, 0);
        repeat (2) tx_drain();

        // R3 narrow writes, upper lanes asserted but ignored
        mode_i = M_NARROW;
        tx_write(64'hFFFF_0000_1234_5678, 8'h0C, 1, 1, 0);
        tx_write(64'h0BAD_0BAD_8765_4321, 8'h01, 0, 1, 0);
        repeat (2) tx_drain();
        idle();
        check("R4 err still clear", {63'h0, be_err_o}, 64'h0);

        // R4 bad enables
        mode_i = M_FULL;
        tx_write(64'h5555_5555_5555_5555, 8'hFA, 1, 0, 0);
        idle();
        check("R4 bad write dropped", {63'h0, tx_empty_o}, 64'h1);
        check("R4 err set", {63'h0, be_err_o}, {63'h0, exp_err});
        tx_write(64'h6666_6666_6666_6666, 8'hFF, 0, 0, 0);
        tx_write(64'h7777_7777_7777_7777, 8'h00, 0, 0, 0);
        idle();
        check("R4 err sticky", {63'h0, be_err_o}, 64'h1);
        tx_drain();

        // R5 full reads, R7 empty read
        rx_load(64'hFEED_FACE_0000_0001, 8'hFF, 1);
        rx_load(64'h0000_0000_0000_0002, 8'h0F, 0);
        rx_read(0);
        rx_read(0);
        rx_read(0);
        idle();
        check("R7 empty after reads", {63'h0, rx_empty_o}, 64'h1);

        // R6 split and narrow reads
        rx_load(64'hAAAA_BBBB_CCCC_DDDD, 8'h3C, 1);
        rx_load(64'h1212_3434_5656_7878, 8'hF8, 0);
        mode_i = M_SPLIT;
        rx_read(0);
        mode_i = M_NARROW;
        rx_read(0);

        // R8 keep
        mode_i = M_FULL;
        rx_load(64'h0000_0000_0000_00AA, 8'h01, 1);
        rx_load(64'h0000_0000_0000_00BB, 8'h03, 0);
        rx_read(1);
        rx_read(0);
        rx_read(0);

        // R9 depth limits
        for (int i = 0; i < 17; i++) rx_load(64'h100 + 64'(i), 8'hFF, 0);
        idle();
        check("R9 rx full", {63'h0, rx_full_o}, 64'h1);
        for (int i = 0; i < 17; i++) rx_read(0);
        idle();
        check("R9 rx empty", {63'h0, rx_empty_o}, 64'h1);
        for (int i = 0; i < 17; i++) tx_write(64'h200 + 64'(i), 8'h00, 0, 0, 0);
        idle();
        check("R9 tx full", {63'h0, tx_full_o}, 64'h1);
        for (int i = 0; i < 17; i++) tx_drain();
        idle();
        check("R9 tx empty", {63'h0, tx_empty_o}, 64'h1);

        // R10 shared bus conflict, then split concurrency
        rx_load(64'h0000_0000_0000_0C01, 8'h0F, 1);
        tx_write(64'h3333_3333_3333_3333, 8'h00, 0, 0, 1);
        idle();
        check("R10 full write blocked", {63'h0, tx_empty_o}, 64'h1);
        mode_i = M_SPLIT;
        rx_load(64'h0000_0000_0000_0C02, 8'h07, 0);
        tx_write(64'h4444_5555_0000_0000, 8'h0F, 0, 1, 1);
        idle();
        check("R10 split write taken", {63'h0, tx_empty_o}, 64'h0);
        check("R10 split read taken", {63'h0, rx_empty_o}, 64'h1);
        tx_drain();
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule